// File: doc/BRIEF.md
# Masked Trap Priority Vector Generator

This unit turns a word of pending trap requests into the address of the handler slot that should run next. Each pending bit is first qualified by a software-writable enable mask. The highest-numbered bit that is still active wins arbitration. Its index is then converted into an entry of a fixed dispatch table that holds one slot per trap source.

The table sits at base address 32. The top source (bit 31) takes the lowest slot and the bottom source (bit 0) takes the highest one. Bit 31 is the reset trap, and it cannot be masked.

The winning address and a valid flag are captured into registers when the capture strobe is pulsed. They are held unchanged until the next strobe. The qualified pending word is also driven out, combinationally, so the surrounding control can inspect it.

Top module: `trapvec_gen`

## Requirements
- R1: After reset, `vec_valid` is 0 and `vec_addr` is 63. The mask reset value enables all sources, so `masked_pend` equals `trap_pend`.
- R2: `masked_pend[i]` equals `trap_pend[i] & en[i]` for bits 30..0, where a mask bit of 1 enables the source. A value written with `mask_we` affects `masked_pend` from the cycle after the write edge.
- R3: Bit 31 bypasses the mask. Its `masked_pend` bit always equals `trap_pend[31]`, and a capture with that bit set yields address 32 even when the mask is all zeros.
- R4: When several masked bits are set, the one with the largest index wins.
- R5: The winning bit N gives `vec_addr` = 32 + (31 − N), so bit 31 gives 32 and bit 0 gives 63.
- R6: A capture with no masked bit set gives `vec_valid` = 0 and `vec_addr` = 63. Otherwise it gives `vec_valid` = 1.
- R7: `vec_addr` and `vec_valid` change only at a clock edge where `capture` is high. At every other edge they hold their values.
- R8: When `mask_we` and `capture` are high in the same cycle, the capture uses the mask in force before that write. The newly written mask governs later captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_pend | input | 32 | Pending trap requests, one bit per source |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 32 | New mask value (bit 31 is stored but has no effect) |
| capture | input | 1 | Registers the current arbitration result |
| vec_addr | output | 6 | Registered dispatch table address (32..63) |
| vec_valid | output | 1 | Registered flag: an enabled trap was pending at capture |
| masked_pend | output | 32 | Pending word after masking (bit 31 unmasked) |

## Verification
The mask write and the capture can fall in the same cycle. The bench provokes this with directed cases and with random stimulus.

In the directed cases, the old mask admits a pending bit that the new mask blocks, and the reverse. The bench then checks that the captured address follows the old mask. It also checks that the next capture, and `masked_pend` in the next cycle, follow the new mask.

In the random phase, both strobes fire independently. A bench model updates its mask copy only after it has computed the expected captured vector, which covers the same-cycle case there as well.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;
    // default number of trap sources and table base
    localparam int unsigned TV_NSRC_DEF  = 32;
    localparam int unsigned TV_VBASE_DEF = 32;
endpackage

// File: rtl/trapvec_prio.sv
// Finds the highest-index set bit of a request word.
module trapvec_prio #(
    parameter int unsigned NSRC  = trapvec_pkg::TV_NSRC_DEF,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  req,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (req[i]) begin
                idx = IDX_W'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trapvec_encode.sv
// Maps a winning index onto the dispatch table: top index -> lowest slot.
module trapvec_encode #(
    parameter int unsigned NSRC   = trapvec_pkg::TV_NSRC_DEF,
    parameter int unsigned VBASE  = trapvec_pkg::TV_VBASE_DEF,
    localparam int unsigned IDX_W  = $clog2(NSRC),
    localparam int unsigned ADDR_W = $clog2(VBASE + NSRC)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              hit,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned LAST = VBASE + NSRC - 1;

    always_comb begin
        if (hit) addr = ADDR_W'(LAST - int'(idx));
        else     addr = ADDR_W'(LAST);
    end
endmodule

// File: rtl/trapvec_gen.sv
module trapvec_gen #(
    parameter int unsigned NSRC  = trapvec_pkg::TV_NSRC_DEF,
    parameter int unsigned VBASE = trapvec_pkg::TV_VBASE_DEF,
    localparam int unsigned IDX_W  = $clog2(NSRC),
    localparam int unsigned ADDR_W = $clog2(VBASE + NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   trap_pend,
    input  logic              mask_we,
    input  logic [NSRC-1:0]   mask_wdata,
    input  logic              capture,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              vec_valid,
    output logic [NSRC-1:0]   masked_pend
);
    localparam logic [NSRC-1:0]   TOP_BIT  = {1'b1, {(NSRC-1){1'b0}}};
    localparam logic [ADDR_W-1:0] IDLE_VEC = ADDR_W'(VBASE + NSRC - 1);

    typedef struct packed {
        logic [NSRC-1:0]   mask;
        logic [ADDR_W-1:0] vec;
        logic              valid;
    } tv_state_t;

    tv_state_t state_d, state_q;

    logic [IDX_W-1:0]  win_idx;
    logic              win_hit;
    logic [ADDR_W-1:0] win_addr;

    // the top source is never gated by the mask
    assign masked_pend = trap_pend & (state_q.mask | TOP_BIT);

    trapvec_prio #(.NSRC(NSRC)) u_prio (
        .req (masked_pend),
        .idx (win_idx),
        .hit (win_hit)
    );

    trapvec_encode #(.NSRC(NSRC), .VBASE(VBASE)) u_enc (
        .idx  (win_idx),
        .hit  (win_hit),
        .addr (win_addr)
    );

    always_comb begin
        state_d = state_q;
        if (mask_we) begin
            state_d.mask = mask_wdata;
        end
        if (capture) begin
            state_d.valid = win_hit;
            state_d.vec   = win_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mask  <= '1;
            state_q.vec   <= IDLE_VEC;
            state_q.valid <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vec_addr  = state_q.vec;
    assign vec_valid = state_q.valid;
endmodule

// File: rtl/trapvec_gen_chk.sv
module trapvec_gen_chk #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned VBASE  = 32,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   trap_pend,
    input logic              capture,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              vec_valid,
    input logic [NSRC-1:0]   masked_pend
);
    localparam logic [ADDR_W-1:0] TOP_VEC  = ADDR_W'(VBASE);
    localparam logic [ADDR_W-1:0] IDLE_VEC = ADDR_W'(VBASE + NSRC - 1);

    // R2
    masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_pend & ~trap_pend) == '0);

    // R3
    top_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        masked_pend[NSRC-1] == trap_pend[NSRC-1]);

    // R3
    top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && trap_pend[NSRC-1]) |=> (vec_valid && vec_addr == TOP_VEC));

    // R6
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == IDLE_VEC);

    // R6
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> vec_valid == $past(|masked_pend));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(vec_addr) && $stable(vec_valid)));
endmodule

bind trapvec_gen trapvec_gen_chk #(.NSRC(NSRC), .VBASE(VBASE), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_pend   (trap_pend),
    .capture     (capture),
    .vec_addr    (vec_addr),
    .vec_valid   (vec_valid),
    .masked_pend (masked_pend)
);

// File: tb/trapvec_gen_bench.sv
`timescale 1ns/1ps
module trapvec_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] trap_pend = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        capture = 1'b0;
    logic [5:0]  vec_addr;
    logic        vec_valid;
    logic [31:0] masked_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mask;
    logic [5:0]  m_vec;
    logic        m_valid;

    always #2.5 clk = ~clk;

    trapvec_gen u_trapvec_gen (
        .clk(clk), .rst_n(rst_n), .trap_pend(trap_pend), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .capture(capture), .vec_addr(vec_addr),
        .vec_valid(vec_valid), .masked_pend(masked_pend)
    );

    function automatic logic [31:0] exp_masked(logic [31:0] p, logic [31:0] m);
        return p & {1'b1, m[30:0]};
    endfunction

    function automatic logic [5:0] exp_vec(logic [31:0] w);
        for (int i = 31; i >= 0; i--) if (w[i]) return 6'(63 - i);
        return 6'd63;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle (called just after a falling edge), then check
    task automatic step(string req, logic [31:0] p, logic we, logic [31:0] wd, logic cap);
        logic [31:0] mw;
        trap_pend = p; mask_we = we; mask_wdata = wd; capture = cap;
        #1;
        mw = exp_masked(p, m_mask);
        chk({req, " masked"}, masked_pend, mw);
        @(posedge clk);
        if (cap) begin
            m_vec = exp_vec(mw);
            m_valid = |mw;
        end
        if (we) m_mask = wd;
        @(negedge clk);
        chk({req, " vec"}, {26'd0, vec_addr}, {26'd0, m_vec});
        chk({req, " valid"}, {31'd0, vec_valid}, {31'd0, m_valid});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mask = '1; m_vec = 6'd63; m_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        trap_pend = 32'hA5A5_0F0F;
        #1;
        chk("R1 vec", {26'd0, vec_addr}, 32'd63);
        chk("R1 valid", {31'd0, vec_valid}, 32'd0);
        chk("R1 masked", masked_pend, 32'hA5A5_0F0F);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: each single bit maps to 63-N
        for (int n = 0; n < 32; n++) step("R5", 32'd1 << n, 1'b0, '0, 1'b1);
        // R6: nothing pending
        step("R6", 32'd0, 1'b0, '0, 1'b1);
        // R4: several bits, highest wins
        step("R4", 32'h0001_0406, 1'b0, '0, 1'b1);
        // R7: hold without capture
        step("R7", 32'h8000_0000, 1'b0, '0, 1'b0);
        step("R7", 32'h0000_0001, 1'b0, '0, 1'b0);
        // R2: mask off upper bits, lower source wins
        step("R2", 32'h0000_0000, 1'b1, 32'h0000_00FF, 1'b0);
        step("R2", 32'h4000_0010, 1'b0, '0, 1'b1);
        step("R2", 32'h4000_0100, 1'b0, '0, 1'b1);
        // R3: mask all zeros, bit 31 still wins
        step("R3", 32'h0, 1'b1, 32'h0, 1'b0);
        step("R3", 32'hFFFF_FFFF, 1'b0, '0, 1'b1);
        step("R3", 32'h7FFF_FFFF, 1'b0, '0, 1'b1);
        // R8: write and capture together; old mask (zeros) applies
        step("R8", 32'h0000_0004, 1'b1, 32'h0000_0004, 1'b1);
        step("R8", 32'h0000_0004, 1'b0, '0, 1'b1);
        // R8: old mask admits, new blocks
        step("R8", 32'h0000_0004, 1'b1, 32'h0000_0000, 1'b1);
        step("R8", 32'h0000_0004, 1'b0, '0, 1'b1);

        // random phase
        for (int k = 0; k < 400; k++) begin
            logic [31:0] p;
            logic [31:0] wd;
            p = $urandom() & $urandom() & $urandom();
            if ($urandom_range(0, 7) == 0) p = '0;
            wd = $urandom() | $urandom();
            step("R4 R8 random", p, ($urandom_range(0, 5) == 0), wd, ($urandom_range(0, 2) != 0));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule